// File: doc/BRIEF.md
# Magnitude Peak-Hold Display Register

This block holds the reading that a measurement front end presents on its display. Each time a conversion finishes, the counter logic raises a one-cycle end-of-conversion strobe together with the new result. The result arrives as a sign bit, an unsigned magnitude and an overrange flag. In tracking mode the register takes every result. In hold mode it keeps only the result of largest absolute size seen so far, so the display never sags between conversions.

The size comparison ignores sign. A larger negative result replaces a smaller positive one. An overrange result ranks above every in-range magnitude. The same register serves voltage readings and frequency counts. While hold mode is selected, the block raises a lock output that stops an attached counter from changing its range on its own. Turning hold off makes the register track again from the next strobe.

Top module: `peak_display_reg`

## Requirements
- R1: After reset the outputs show magnitude 0, a positive sign (`disp_neg` = 0), a cleared overrange flag and a low `range_lock`.
- R2: Without an end-of-conversion strobe (`eoc` = 0), `disp_neg`, `disp_mag` and `disp_ovr` keep their values indefinitely, with no decay.
- R3: With `hold_en` = 0, every cycle with `eoc` = 1 loads `new_neg`, `new_mag` and `new_ovr`, and they appear on the outputs one clock later.
- R4: With `hold_en` = 1 and both results in range, a strobe whose `new_mag` is strictly greater than `disp_mag` loads the new result together with its own sign, whatever the two signs are.
- R5: With `hold_en` = 1 and both results in range, a strobe whose `new_mag` is less than or equal to `disp_mag` leaves all outputs unchanged. On an equal magnitude the earlier sign stays shown.
- R6: With `hold_en` = 1, an overrange result (`new_ovr` = 1) replaces any held in-range value. While an overrange value is held, no result replaces it, whether that result is in range or is itself overrange.
- R7: After `hold_en` returns to 0, the next strobe loads its result even when that result is smaller than the held one.
- R8: `range_lock` equals the value `hold_en` had in the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eoc | input | 1 | One-cycle strobe: a new conversion result is valid |
| new_neg | input | 1 | Sign of the new result, 1 = negative |
| new_mag | input | MAG_W | Magnitude of the new result |
| new_ovr | input | 1 | New result is beyond full scale |
| hold_en | input | 1 | 1 = keep the largest-magnitude result, 0 = track every result |
| disp_neg | output | 1 | Displayed sign |
| disp_mag | output | MAG_W | Displayed magnitude |
| disp_ovr | output | 1 | Displayed overrange flag |
| range_lock | output | 1 | Inhibits autoranging in the attached counter while hold is active |

## Verification
The properties assume that the result fields are settled in every cycle that carries a strobe, and that `hold_en` is changed only between strobes, never in the same cycle as one. The stimulus changes the result fields and `hold_en` on falling clock edges only. It pulses `eoc` for exactly one cycle and leaves idle cycles between strobes. Mode changes are made while `eoc` is low, so every comparison the properties make sees one well-defined mode.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    localparam int unsigned PDR_DEF_MAG_W = 13;

    // ordering of one magnitude against another
    typedef enum logic [1:0] {
        RANK_BELOW = 2'd0,
        RANK_EQUAL = 2'd1,
        RANK_ABOVE = 2'd2
    } rank_e;

endpackage

// File: rtl/pdr_mag_cmp.sv
module pdr_mag_cmp
    import pdr_pkg::*;
#(
    parameter int unsigned W = PDR_DEF_MAG_W
) (
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    output rank_e        a_vs_b
);

    // MSB-first decision chain: the first differing bit settles the order
    logic [W:0] decided;
    logic [W:0] a_wins;

    assign decided[W] = 1'b0;
    assign a_wins[W]  = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        assign decided[i] = decided[i+1] | (a_mag[i] ^ b_mag[i]);
        assign a_wins[i]  = decided[i+1] ? a_wins[i+1] : (a_mag[i] & ~b_mag[i]);
    end

    always_comb begin
        if (!decided[0]) begin
            a_vs_b = RANK_EQUAL;
        end else if (a_wins[0]) begin
            a_vs_b = RANK_ABOVE;
        end else begin
            a_vs_b = RANK_BELOW;
        end
    end

endmodule

// File: rtl/pdr_rank.sv
module pdr_rank
    import pdr_pkg::*;
(
    input  logic  cand_ovr,
    input  logic  held_ovr,
    input  rank_e mag_order,
    output logic  cand_beats
);

    // overrange sits above every in-range magnitude; two overranges tie
    always_comb begin
        unique case ({cand_ovr, held_ovr})
            2'b10:   cand_beats = 1'b1;
            2'b01:   cand_beats = 1'b0;
            2'b11:   cand_beats = 1'b0;
            default: cand_beats = (mag_order == RANK_ABOVE);
        endcase
    end

endmodule

// File: rtl/pdr_load_ctrl.sv
module pdr_load_ctrl (
    input  logic strobe,
    input  logic hold_mode,
    input  logic cand_beats,
    output logic take_new
);

    always_comb begin
        take_new = 1'b0;
        if (strobe) begin
            take_new = hold_mode ? cand_beats : 1'b1;
        end
    end

endmodule

// File: rtl/peak_display_reg.sv
module peak_display_reg
    import pdr_pkg::*;
#(
    parameter int unsigned MAG_W = PDR_DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic             new_neg,
    input  logic [MAG_W-1:0] new_mag,
    input  logic             new_ovr,
    input  logic             hold_en,
    output logic             disp_neg,
    output logic [MAG_W-1:0] disp_mag,
    output logic             disp_ovr,
    output logic             range_lock
);

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
        logic             ovr;
        logic             lock;
    } state_t;

    state_t state_d;
    state_t state_q;

    rank_e  mag_order;
    logic   cand_beats;
    logic   take_new;

    pdr_mag_cmp #(
        .W (MAG_W)
    ) u_cmp (
        .a_mag  (new_mag),
        .b_mag  (state_q.mag),
        .a_vs_b (mag_order)
    );

    pdr_rank u_rank (
        .cand_ovr   (new_ovr),
        .held_ovr   (state_q.ovr),
        .mag_order  (mag_order),
        .cand_beats (cand_beats)
    );

    pdr_load_ctrl u_load (
        .strobe     (eoc),
        .hold_mode  (hold_en),
        .cand_beats (cand_beats),
        .take_new   (take_new)
    );

    always_comb begin
        state_d      = state_q;
        state_d.lock = hold_en;
        if (take_new) begin
            state_d.neg = new_neg;
            state_d.mag = new_mag;
            state_d.ovr = new_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign disp_neg   = state_q.neg;
    assign disp_mag   = state_q.mag;
    assign disp_ovr   = state_q.ovr;
    assign range_lock = state_q.lock;

endmodule

// File: rtl/peak_display_reg_chk.sv
module peak_display_reg_chk #(
    parameter int unsigned MAG_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eoc,
    input logic             new_neg,
    input logic [MAG_W-1:0] new_mag,
    input logic             new_ovr,
    input logic             hold_en,
    input logic             disp_neg,
    input logic [MAG_W-1:0] disp_mag,
    input logic             disp_ovr,
    input logic             range_lock
);

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc |=> ($stable(disp_mag) && $stable(disp_neg) && $stable(disp_ovr)));

    p_track_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !hold_en) |=> (disp_mag == $past(new_mag) && disp_neg == $past(new_neg)
                               && disp_ovr == $past(new_ovr)));

    p_peak_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && hold_en && !new_ovr && !disp_ovr && new_mag > disp_mag)
        |=> (disp_mag == $past(new_mag) && disp_neg == $past(new_neg)));

    p_peak_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && hold_en && !new_ovr && !disp_ovr && new_mag <= disp_mag)
        |=> ($stable(disp_mag) && $stable(disp_neg) && $stable(disp_ovr)));

    p_ovr_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && hold_en && new_ovr && !disp_ovr) |=> disp_ovr);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && hold_en && disp_ovr)
        |=> ($stable(disp_mag) && $stable(disp_neg) && disp_ovr));

    p_lock_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (range_lock == $past(hold_en)));

endmodule

bind peak_display_reg peak_display_reg_chk #(
    .MAG_W (MAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eoc        (eoc),
    .new_neg    (new_neg),
    .new_mag    (new_mag),
    .new_ovr    (new_ovr),
    .hold_en    (hold_en),
    .disp_neg   (disp_neg),
    .disp_mag   (disp_mag),
    .disp_ovr   (disp_ovr),
    .range_lock (range_lock)
);

// File: tb/peak_display_reg_test.sv
module peak_display_reg_test;

    localparam int unsigned MAG_W = 13;

    typedef struct {
        logic             neg;
        logic [MAG_W-1:0] mag;
        logic             ovr;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             eoc = 1'b0;
    logic             new_neg = 1'b0;
    logic [MAG_W-1:0] new_mag = '0;
    logic             new_ovr = 1'b0;
    logic             hold_en = 1'b0;
    logic             disp_neg;
    logic [MAG_W-1:0] disp_mag;
    logic             disp_ovr;
    logic             range_lock;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb_q[$];
    logic strobe_seen = 1'b0;

    // independent model of the displayed value
    logic             m_neg = 1'b0;
    logic [MAG_W-1:0] m_mag = '0;
    logic             m_ovr = 1'b0;

    always #5 clk = ~clk;

    peak_display_reg #(.MAG_W(MAG_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .eoc        (eoc),
        .new_neg    (new_neg),
        .new_mag    (new_mag),
        .new_ovr    (new_ovr),
        .hold_en    (hold_en),
        .disp_neg   (disp_neg),
        .disp_mag   (disp_mag),
        .disp_ovr   (disp_ovr),
        .range_lock (range_lock)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_display(input string tag);
        check_val({tag, " sign"}, {31'd0, disp_neg}, {31'd0, m_neg});
        check_val({tag, " mag"}, {{(32-MAG_W){1'b0}}, disp_mag}, {{(32-MAG_W){1'b0}}, m_mag});
        check_val({tag, " ovr"}, {31'd0, disp_ovr}, {31'd0, m_ovr});
    endtask

    // driver: present one result with a one-cycle strobe, push the expectation
    task automatic post(input logic neg, input int mag, input logic ovr, input string tag);
        exp_t e;
        logic beats;
        beats = (ovr && !m_ovr) || (!ovr && !m_ovr && (mag > int'(m_mag)));
        if (!hold_en || beats) begin
            m_neg = neg;
            m_mag = MAG_W'(mag);
            m_ovr = ovr;
        end
        e.neg = m_neg; e.mag = m_mag; e.ovr = m_ovr; e.tag = tag;
        sb_q.push_back(e);
        new_neg = neg;
        new_mag = MAG_W'(mag);
        new_ovr = ovr;
        eoc     = 1'b1;
        @(negedge clk);
        eoc = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor
    always @(posedge clk) strobe_seen <= eoc && rst_n;

    always @(negedge clk) begin
        if (strobe_seen) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL scoreboard: strobe with no expectation, actual mag %0d expected none", disp_mag);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check_val({e.tag, " sign"}, {31'd0, disp_neg}, {31'd0, e.neg});
                check_val({e.tag, " mag"}, {{(32-MAG_W){1'b0}}, disp_mag}, {{(32-MAG_W){1'b0}}, e.mag});
                check_val({e.tag, " ovr"}, {31'd0, disp_ovr}, {31'd0, e.ovr});
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_display("R1 reset");
        check_val("R1 range_lock", {31'd0, range_lock}, 32'd0);

        // R3 tracking mode
        post(1'b0, 1234, 1'b0, "R3 track positive");
        post(1'b1, 57,   1'b0, "R3 track smaller negative");
        post(1'b0, 4000, 1'b1, "R3 track overrange");
        post(1'b0, 12,   1'b0, "R3 track after overrange");

        // R2 no strobe, no drift
        idle(20);
        check_display("R2 idle tracking");

        // R8 lock follows hold
        hold_en = 1'b1;
        @(negedge clk);
        check_val("R8 lock set", {31'd0, range_lock}, 32'd1);

        // R4 / R5 peak comparisons by magnitude only
        post(1'b0, 300, 1'b0, "R4 larger positive");
        post(1'b1, 900, 1'b0, "R4 larger negative replaces positive");
        post(1'b0, 500, 1'b0, "R5 smaller ignored");
        post(1'b0, 900, 1'b0, "R5 equal keeps earlier sign");
        post(1'b1, 899, 1'b0, "R5 one below ignored");

        // R6 overrange ranking
        post(1'b0, 20,   1'b1, "R6 overrange captured");
        post(1'b1, 8191, 1'b0, "R6 in-range max ignored");
        post(1'b1, 5,    1'b1, "R6 second overrange ignored");

        idle(15);
        check_display("R2 idle holding");

        // R7 release
        hold_en = 1'b0;
        @(negedge clk);
        check_val("R8 lock clear", {31'd0, range_lock}, 32'd0);
        check_display("R7 release alone changes nothing");
        post(1'b0, 3, 1'b0, "R7 small loads after release");

        hold_en = 1'b1;
        @(negedge clk);
        post(1'b1, 0, 1'b0, "R5 zero ignored");
        post(1'b0, 4, 1'b0, "R4 one above loads");

        idle(2);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule